// File: doc/BRIEF.md
# Per-Thread Return Address Stack with Checkpoint Repair

This block predicts return targets for a multithreaded fetch stage. Each hardware thread owns its own circular stack of return addresses. A call that is predicted taken pushes its PC onto the stack of its thread. A return that is predicted taken reads the top entry as its target and then pops it. The index and value of the top are always visible, so the history logic can save them into its prediction record before the pop.

Predictions are speculative, so wrong-path work must be undone. Two repair commands serve this purpose. A restore writes back a saved top index and writes the saved value into that slot, which reverses a speculative pop. A pop reverses a speculative push. The history queue decides when to repair. The stack only carries out the commands it receives. Only one command is applied per cycle, and the command names its thread. A separate view thread selects which stack drives the outputs.

Top module: `ras_bank`

## Requirements
- R1: After reset every thread's stack is empty (`empty`=1) and its top index is 0.
- R2: A push (`cmd_op`=1) advances the selected thread's top index by one, wrapping from DEPTH-1 to 0. It writes `push_pc` into the new top slot and clears `empty`. All of this is visible on the cycle after the command.
- R3: A pop (`cmd_op`=2) on a non-empty stack moves the top index back by one, wrapping from 0 to DEPTH-1, and lowers the occupancy by one. Entries therefore come back in last-in first-out order.
- R4: A pop on an empty stack leaves the top index and the empty flag unchanged.
- R5: A push on a full stack overwrites the oldest entry and the occupancy stays at DEPTH. Exactly DEPTH pops then empty the stack, and they return the DEPTH most recent pushes in reverse order.
- R6: A restore (`cmd_op`=3) sets the top index to `rst_idx` and writes `rst_val` into that slot. It also raises the occupancy by one, saturating at DEPTH.
- R7: A command acts only on the stack of `cmd_tid`. Every other thread's top index, top value and empty flag stay unchanged.
- R8: `top_val`, `top_idx` and `empty` show the stack of `view_tid` combinationally. A no-op (`cmd_op`=0) changes nothing.
- R9: A pop issued after a wrong-path push brings the top index and top value back to what they were before that push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 2 | 0 no-op, 1 push, 2 pop, 3 restore |
| cmd_tid | input | TID_W | Thread that the command acts on |
| push_pc | input | ADDR_W | Call PC to push |
| rst_idx | input | IDX_W | Saved top index for restore |
| rst_val | input | ADDR_W | Saved top value for restore |
| view_tid | input | TID_W | Thread whose stack drives the outputs |
| top_val | output | ADDR_W | Top entry of the viewed stack |
| top_idx | output | IDX_W | Top index of the viewed stack |
| empty | output | 1 | Viewed stack holds no entries |

## Verification
The assertions assume that `cmd_tid` names an existing thread. They also assume that `rst_idx` is below DEPTH, because a restore checks the slot it wrote by reading it back. The stimulus only uses thread numbers 0 and 1, and it only restores indices that it captured from `top_idx` earlier. Pops on an empty stack are sent on purpose to exercise the hold behaviour. Top values are never compared while a stack is empty, because the slots are not reset.

// File: rtl/ras_pkg.sv
// Package ras_pkg
// Shared command encoding for the return address stack.
// Assumes: the command port is two bits wide.
package ras_pkg;
    typedef enum logic [1:0] {
        RAS_NOP     = 2'd0,
        RAS_PUSH    = 2'd1,
        RAS_POP     = 2'd2,
        RAS_RESTORE = 2'd3
    } ras_op_e;
endpackage

// File: rtl/ras_ptr_ctrl.sv
// Module ras_ptr_ctrl
// Keeps the circular top pointer and the saturating occupancy count of one stack.
// Assumes: at most one of the do_* strobes is high in any cycle, and rst_idx < DEPTH.
module ras_ptr_ctrl #(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_push,
    input  logic             do_pop,
    input  logic             do_restore,
    input  logic [IDX_W-1:0] rst_idx,
    output logic [IDX_W-1:0] top_idx,
    output logic [IDX_W-1:0] push_slot,
    output logic             empty
);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] pop_slot;

    // Neighbour slots of the top pointer, with wrap.
    always_comb begin
        push_slot = (top_idx == LAST) ? '0 : top_idx + 1'b1;
        pop_slot  = (top_idx == '0) ? LAST : top_idx - 1'b1;
    end

    assign empty = (count == '0);

    // Top pointer and occupancy updates per command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_idx <= '0;
            count   <= '0;
        end else if (do_push) begin
            top_idx <= push_slot;
            if (count != FULLC) count <= count + 1'b1;
        end else if (do_pop) begin
            if (count != '0) begin
                top_idx <= pop_slot;
                count   <= count - 1'b1;
            end
        end else if (do_restore) begin
            top_idx <= rst_idx;
            if (count != FULLC) count <= count + 1'b1;
        end
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULLC); // R5
    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && empty) |=> (empty && $stable(top_idx))); // R4
    AST_PUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> !empty); // R2
    AST_FULL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && count == FULLC) |=> (count == FULLC)); // R5
    AST_RESTORE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        do_restore |=> (top_idx == $past(rst_idx))); // R6
endmodule

// File: rtl/ras_thread.sv
// Module ras_thread
// One thread's return address stack: entry storage plus its pointer controller.
// Assumes: commands arrive already decoded for this thread via sel. Entries are not reset.
module ras_thread
    import ras_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  ras_op_e           op,
    input  logic [ADDR_W-1:0] push_pc,
    input  logic [IDX_W-1:0]  rst_idx,
    input  logic [ADDR_W-1:0] rst_val,
    output logic [ADDR_W-1:0] top_val,
    output logic [IDX_W-1:0]  top_idx,
    output logic              empty
);
    logic [ADDR_W-1:0] slots [DEPTH];
    logic [IDX_W-1:0]  push_slot;
    logic do_push, do_pop, do_restore;

    // Decode the command for this thread only.
    always_comb begin
        do_push    = sel && (op == RAS_PUSH);
        do_pop     = sel && (op == RAS_POP);
        do_restore = sel && (op == RAS_RESTORE);
    end

    ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_push    (do_push),
        .do_pop     (do_pop),
        .do_restore (do_restore),
        .rst_idx    (rst_idx),
        .top_idx    (top_idx),
        .push_slot  (push_slot),
        .empty      (empty)
    );

    // Entry writes: push fills the next slot, restore repairs the saved slot.
    always_ff @(posedge clk) begin
        if (do_push)
            slots[push_slot] <= push_pc;
        else if (do_restore)
            slots[rst_idx] <= rst_val;
    end

    assign top_val = slots[top_idx];

    AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> (top_val == $past(push_pc))); // R2
    AST_RESTORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        do_restore |=> (top_val == $past(rst_val))); // R6
    AST_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel || op == RAS_NOP) |=> ($stable(top_idx) && $stable(empty))); // R7
endmodule

// File: rtl/ras_bank.sv
// Module ras_bank
// Bank of independent return address stacks, one per hardware thread.
// Assumes: cmd_tid and view_tid name existing threads; one command per cycle.
module ras_bank
    import ras_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int DEPTH       = 16,
    parameter int ADDR_W      = 32,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic [TID_W-1:0]  cmd_tid,
    input  logic [ADDR_W-1:0] push_pc,
    input  logic [IDX_W-1:0]  rst_idx,
    input  logic [ADDR_W-1:0] rst_val,
    input  logic [TID_W-1:0]  view_tid,
    output logic [ADDR_W-1:0] top_val,
    output logic [IDX_W-1:0]  top_idx,
    output logic              empty
);
    ras_op_e           op;
    logic [ADDR_W-1:0] th_val   [NUM_THREADS];
    logic [IDX_W-1:0]  th_idx   [NUM_THREADS];
    logic              th_empty [NUM_THREADS];

    assign op = ras_op_e'(cmd_op);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        ras_thread #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_thr (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (cmd_tid == TID_W'(t)),
            .op      (op),
            .push_pc (push_pc),
            .rst_idx (rst_idx),
            .rst_val (rst_val),
            .top_val (th_val[t]),
            .top_idx (th_idx[t]),
            .empty   (th_empty[t])
        );
    end

    // Output view of the selected thread.
    always_comb begin
        top_val = '0;
        top_idx = '0;
        empty   = 1'b1;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (view_tid == TID_W'(t)) begin
                top_val = th_val[t];
                top_idx = th_idx[t];
                empty   = th_empty[t];
            end
        end
    end

    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RAS_NOP && $stable(view_tid)) |=> ($stable(top_idx) && $stable(empty))); // R8
endmodule

// File: tb/ras_bank_bench.sv
// Directed bench for ras_bank: one task per scenario, each checking its own results.
module ras_bank_bench;
    localparam int NT = 2, D = 16, AW = 32;
    localparam int TW = 1, IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [TW-1:0] cmd_tid = '0;
    logic [AW-1:0] push_pc = '0;
    logic [IW-1:0] rst_idx = '0;
    logic [AW-1:0] rst_val = '0;
    logic [TW-1:0] view_tid = '0;
    logic [AW-1:0] top_val;
    logic [IW-1:0] top_idx;
    logic          empty;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    ras_bank #(.NUM_THREADS(NT), .DEPTH(D), .ADDR_W(AW)) u_ras_bank (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_tid(cmd_tid),
        .push_pc(push_pc), .rst_idx(rst_idx), .rst_val(rst_val),
        .view_tid(view_tid), .top_val(top_val), .top_idx(top_idx), .empty(empty)
    );

    task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one command on a falling edge. Returns on the next falling edge with the result visible.
    task automatic issue(logic [1:0] op, logic [TW-1:0] tid, logic [AW-1:0] pc,
                         logic [IW-1:0] idx, logic [AW-1:0] val);
        @(negedge clk);
        cmd_op = op; cmd_tid = tid; push_pc = pc; rst_idx = idx; rst_val = val;
        @(negedge clk);
        cmd_op = 2'd0;
        view_tid = tid;
        #1;
    endtask

    task automatic look(logic [TW-1:0] tid);
        view_tid = tid;
        #1;
    endtask

    task automatic t_reset();
        for (int t = 0; t < NT; t++) begin
            look(TW'(t));
            chk("R1", "empty", AW'(empty), 1);
            chk("R1", "idx", AW'(top_idx), 0);
        end
    endtask

    task automatic t_push_pop();
        issue(1, 0, 32'hA000, 0, 0);
        issue(1, 0, 32'hB000, 0, 0);
        issue(1, 0, 32'hC000, 0, 0);
        chk("R2", "idx", AW'(top_idx), 3);
        chk("R2", "val", top_val, 32'hC000);
        chk("R2", "empty", AW'(empty), 0);
        issue(2, 0, 0, 0, 0);
        chk("R3", "idx", AW'(top_idx), 2);
        chk("R3", "val", top_val, 32'hB000);
        issue(2, 0, 0, 0, 0);
        chk("R3", "val", top_val, 32'hA000);
        issue(2, 0, 0, 0, 0);
        chk("R3", "empty", AW'(empty), 1);
        chk("R3", "idx", AW'(top_idx), 0);
        issue(2, 0, 0, 0, 0);
        chk("R4", "idx", AW'(top_idx), 0);
        chk("R4", "empty", AW'(empty), 1);
        issue(0, 0, 32'hDEAD, 5, 32'hBEEF);
        chk("R8", "nop idx", AW'(top_idx), 0);
        chk("R8", "nop empty", AW'(empty), 1);
    endtask

    task automatic t_threads();
        issue(1, 1, 32'h1111, 0, 0);
        chk("R7", "t1 idx", AW'(top_idx), 1);
        chk("R7", "t1 val", top_val, 32'h1111);
        look(0);
        chk("R7", "t0 idx", AW'(top_idx), 0);
        chk("R7", "t0 empty", AW'(empty), 1);
        look(1);
        chk("R8", "view t1", top_val, 32'h1111);
    endtask

    task automatic t_wrap();
        for (int k = 1; k <= D + 1; k++) issue(1, 0, AW'(32'h5000 + k), 0, 0);
        chk("R5", "wrap idx", AW'(top_idx), 1);
        chk("R5", "wrap val", top_val, 32'h5000 + D + 1);
        for (int k = 1; k < D; k++) begin
            issue(2, 0, 0, 0, 0);
            chk("R5", "lifo val", top_val, AW'(32'h5000 + D + 1 - k));
        end
        chk("R5", "not yet empty", AW'(empty), 0);
        issue(2, 0, 0, 0, 0);
        chk("R5", "empty after depth pops", AW'(empty), 1);
        chk("R5", "final idx", AW'(top_idx), 1);
        look(1);
        chk("R7", "t1 untouched", top_val, 32'h1111);
    endtask

    task automatic t_repair();
        logic [IW-1:0] sv_idx;
        logic [AW-1:0] sv_val;
        look(1);
        sv_idx = top_idx;
        sv_val = top_val;
        issue(2, 1, 0, 0, 0);
        chk("R3", "return pop", AW'(empty), 1);
        issue(1, 1, 32'h7777, 0, 0);
        chk("R2", "wrong-path push", top_val, 32'h7777);
        issue(2, 1, 0, 0, 0);
        chk("R9", "undo push idx", AW'(top_idx), 0);
        issue(3, 1, 0, sv_idx, sv_val);
        chk("R6", "restore idx", AW'(top_idx), AW'(sv_idx));
        chk("R6", "restore val", top_val, sv_val);
        chk("R6", "restore empty", AW'(empty), 0);
        issue(1, 1, 32'h8888, 0, 0);
        issue(2, 1, 0, 0, 0);
        chk("R9", "undo push val", top_val, sv_val);
        chk("R9", "undo push idx2", AW'(top_idx), AW'(sv_idx));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_push_pop();
        t_threads();
        t_wrap();
        t_repair();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule